// File: doc/BRIEF.md
# Interrupt Flag Collector with Priority Offset Readout

This block gathers interrupt events from a parameterised number of numbered sources, for example the instruction slots of a timer program. Each source has an enable bit. When an enabled source signals an event, its flag latches and stays set until software clears it. A single request line goes to the CPU. It is high while any flag is both set and enabled.

Software reaches the block through a small register port with four word addresses: flags, enable-set, enable-clear and priority offset. Flags can be cleared directly by writing ones to them. Alternatively, software can read the offset word. That read names the most urgent pending source and retires that one flag as a side effect. A handler therefore loops on the offset word until it reads zero, and only then does the request line drop. While the debug input is high, offset reads report the code but leave the flags untouched, so a debugger can inspect the block without losing events.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, every flag and every enable bit is 0, `irq` is low and `bus_rdata` is 0.
- R2: A pulse on `src_evt[i]` while enable bit i is 1 sets flag i at the next rising edge, and the flag then stays set. A pulse on a disabled source leaves its flag at 0.
- R3: A write to address 0 (flags) clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. A read of address 0 returns the raw flag vector.
- R4: A write to address 1 sets the enable bits whose data bits are 1. A write to address 2 clears the enable bits whose data bits are 1. A read of either address returns the current enable mask.
- R5: A read of address 3 returns the offset code. Pending means set and enabled, and the lowest pending index has the highest priority. The code is that index plus 1, or 0 when nothing is pending.
- R6: With `dbg_mode` low, an offset read clears exactly the flag that it reported and no other flag.
- R7: With `dbg_mode` high, an offset read returns the code but clears no flag.
- R8: `irq` is high exactly when at least one flag is both set and enabled. It follows flag and enable changes without extra delay.
- R9: When an enabled event and a clear (either a write-1 clear or an offset-read clear) hit the same flag in the same cycle, the flag ends up set.
- R10: A write to address 3 changes neither the flags nor the enables.
- R11: Read data is registered. `bus_rdata` takes the value for a read on the rising edge that accepts the read, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 flags, 1 enable-set, 2 enable-clear, 3 offset |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| src_evt | input | NUM_SRC | Event pulses, one bit per source |
| dbg_mode | input | 1 | High suppresses the offset-read clear |
| irq | output | 1 | Request line to the CPU |

## Verification
Flags and enables change on the rising edge that samples an event or a write, and `irq` follows in that same cycle because it is combinational from those registers. Offset and register reads show their data on `bus_rdata` one edge after the strobe, and the clear side effect of an offset read lands on that same edge. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Same-cycle collisions are created by driving an event and an access together in one falling-edge slot.

// File: rtl/ifo_pkg.sv
// Shared definitions for the interrupt flag collector.
// Assumes a fixed four-word register window.
package ifo_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS  = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_OFFSET = 2'd3
    } ifo_reg_e;
endpackage

// File: rtl/ifo_prio_enc.sv
// Lowest-index-first priority encoder.
// Produces the offset code (index+1, 0 when idle) and a one-hot of the winner.
// Assumes CODE_W can hold NUM_SRC.
module ifo_prio_enc #(
    parameter int NUM_SRC = 32,
    parameter int CODE_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic [CODE_W-1:0]  code,
    output logic [NUM_SRC-1:0] winner
);
    // Scan from the top down so the lowest pending index is written last and wins.
    always_comb begin
        code   = '0;
        winner = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code   = CODE_W'(i + 1);
                winner = '0;
                winner[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ifo_flag_bank.sv
// One sticky flag per source. A set request beats a clear request in the same cycle.
// Assumes set and clear vectors are already qualified by the caller.
module ifo_flag_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] flags
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        // Hold, set or clear one flag bit, with set taking precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set_vec[g])
                flags[g] <= 1'b1;
            else if (clr_vec[g])
                flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/ifo_enable_reg.sv
// Enable mask written through separate set and clear strobes.
// Assumes at most one strobe per cycle. If both are high, the clear is applied last.
module ifo_enable_reg #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_wr,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] en
);
    logic [NUM_SRC-1:0] en_next;

    // Apply the set mask and then the clear mask to the current enables.
    always_comb begin
        en_next = en;
        if (set_wr) en_next = en_next | wdata;
        if (clr_wr) en_next = en_next & ~wdata;
    end

    // Register the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= en_next;
    end
endmodule

// File: rtl/irq_flag_unit.sv
// Interrupt flag collector with a priority offset readout.
// Sticky per-source flags, a write-1-clear flag word, a set/clear enable pair,
// and an offset word whose read retires the top pending flag unless dbg_mode is high.
// Assumes a single-cycle bus_sel strobe per access. Read data is registered.
module irq_flag_unit #(
    parameter int NUM_SRC = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ifo_pkg::ADDR_W-1:0] bus_addr,
    input  logic [NUM_SRC-1:0]         bus_wdata,
    output logic [NUM_SRC-1:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]         src_evt,
    input  logic                       dbg_mode,
    output logic                       irq
);
    import ifo_pkg::*;

    localparam int CODE_W = $clog2(NUM_SRC + 1);

    ifo_reg_e           reg_sel;
    logic               wr_flags, wr_en_set, wr_en_clr, rd_offset, rd_any;
    logic [NUM_SRC-1:0] flag_q, en_q, pend, winner, set_vec, clr_vec;
    logic [CODE_W-1:0]  ofs_code;
    logic [NUM_SRC-1:0] rd_mux;

    assign reg_sel = ifo_reg_e'(bus_addr);

    // Decode the access strobe into per-register actions.
    always_comb begin
        wr_flags  = bus_sel &&  bus_wr && (reg_sel == REG_FLAGS);
        wr_en_set = bus_sel &&  bus_wr && (reg_sel == REG_EN_SET);
        wr_en_clr = bus_sel &&  bus_wr && (reg_sel == REG_EN_CLR);
        rd_offset = bus_sel && !bus_wr && (reg_sel == REG_OFFSET);
        rd_any    = bus_sel && !bus_wr;
    end

    assign pend = flag_q & en_q;

    ifo_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_prio (
        .pend   (pend),
        .code   (ofs_code),
        .winner (winner)
    );

    // Form the per-bit set and clear requests for the flag bank.
    always_comb begin
        set_vec = src_evt & en_q;
        clr_vec = '0;
        if (wr_flags)              clr_vec = clr_vec | bus_wdata;
        if (rd_offset && !dbg_mode) clr_vec = clr_vec | winner;
    end

    ifo_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flag_q)
    );

    ifo_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (wr_en_set),
        .clr_wr (wr_en_clr),
        .wdata  (bus_wdata),
        .en     (en_q)
    );

    // Select the word returned by a read.
    always_comb begin
        unique case (reg_sel)
            REG_FLAGS:  rd_mux = flag_q;
            REG_EN_SET: rd_mux = en_q;
            REG_EN_CLR: rd_mux = en_q;
            REG_OFFSET: rd_mux = NUM_SRC'(ofs_code);
            default:    rd_mux = '0;
        endcase
    end

    // Capture read data on the accepting edge and hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= rd_mux;
    end

    // Raise the request while any enabled flag is pending.
    assign irq = |pend;
endmodule

// File: rtl/irq_flag_unit_chk.sv
// Property checker for irq_flag_unit, attached by bind.
// Assumes address encodings from ifo_pkg.
module irq_flag_unit_chk #(
    parameter int NUM_SRC = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [ifo_pkg::ADDR_W-1:0] bus_addr,
    input logic [NUM_SRC-1:0]         bus_wdata,
    input logic [NUM_SRC-1:0]         src_evt,
    input logic                       dbg_mode,
    input logic                       irq,
    input logic [NUM_SRC-1:0]         flags,
    input logic [NUM_SRC-1:0]         en
);
    import ifo_pkg::*;

    logic is_rd_ofs, is_wr_flg, is_wr_set;
    assign is_rd_ofs = bus_sel && !bus_wr && (bus_addr == REG_OFFSET);
    assign is_wr_flg = bus_sel &&  bus_wr && (bus_addr == REG_FLAGS);
    assign is_wr_set = bus_sel &&  bus_wr && (bus_addr == REG_EN_SET);

    // R2: an enabled event is reflected in the flags one edge later
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_evt & en)) |=> ((flags & $past(src_evt & en)) == $past(src_evt & en)));

    // R3: written ones clear flags unless an event re-sets them
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr_flg |=> ((flags & $past(bus_wdata & ~(src_evt & en))) == '0));

    // R4: enable-set write turns on the written bits
    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr_set |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));

    // R6: a normal offset read with no events removes at most one flag, and one if any was pending
    p_ofs_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd_ofs && !dbg_mode && (src_evt == '0)) |=>
        ($countones(flags) + (($past(flags & en) != '0) ? 1 : 0) == $countones($past(flags))));

    // R7: debug-mode offset read leaves flags as they were, plus new events
    p_dbg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd_ofs && dbg_mode) |=> (flags == ($past(flags) | $past(src_evt & en))));

    // R8: the request line needs some flag behind it
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & en) != '0));
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_evt   (src_evt),
    .dbg_mode  (dbg_mode),
    .irq       (irq),
    .flags     (flag_q),
    .en        (en_q)
);

// File: tb/sim_irq_flag_unit.sv
// Directed bench for irq_flag_unit: one task per scenario.
// Drives on falling edges and samples on the falling edge after the active edge.
module sim_irq_flag_unit;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] src_evt = '0;
    logic         dbg_mode = 1'b0;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_flag_unit #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_evt(src_evt), .dbg_mode(dbg_mode), .irq(irq)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [N-1:0] d, input logic [N-1:0] ev = '0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_evt = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; src_evt = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [N-1:0] d, input logic [N-1:0] ev = '0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; src_evt = ev;
        @(negedge clk);
        bus_sel = 1'b0; src_evt = '0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] ev);
        @(negedge clk);
        src_evt = ev;
        @(negedge clk);
        src_evt = '0;
    endtask

    // Return flags and enables to zero between scenarios.
    task automatic scrub();
        wr_reg(2'd2, '1);
        wr_reg(2'd0, '1);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        check("R1 irq after reset", N'(irq), '0);
        check("R1 rdata after reset", bus_rdata, '0);
        rd_reg(2'd0, d); check("R1 flags after reset", d, '0);
        rd_reg(2'd1, d); check("R1 enables after reset", d, '0);
    endtask

    task automatic t_enables();
        logic [N-1:0] d;
        wr_reg(2'd1, 32'hF0F0_0001);
        rd_reg(2'd1, d); check("R4 mask via set addr", d, 32'hF0F0_0001);
        rd_reg(2'd2, d); check("R4 mask via clr addr", d, 32'hF0F0_0001);
        wr_reg(2'd2, 32'h0000_0001);
        rd_reg(2'd1, d); check("R4 mask after clear", d, 32'hF0F0_0000);
    endtask

    task automatic t_events();
        logic [N-1:0] d;
        check("R8 irq idle", N'(irq), '0);
        pulse('1);
        check("R8 irq after enabled event", N'(irq), 1);
        rd_reg(2'd0, d); check("R2 only enabled sources latch", d, 32'hF0F0_0000);
        repeat (3) @(negedge clk);
        rd_reg(2'd0, d); check("R2 flags sticky", d, 32'hF0F0_0000);
        check("R11 rdata holds between reads", bus_rdata, 32'hF0F0_0000);
    endtask

    task automatic t_w1c();
        logic [N-1:0] d;
        wr_reg(2'd0, 32'h3000_0000);
        rd_reg(2'd0, d); check("R3 write-one clears", d, 32'hC0F0_0000);
        wr_reg(2'd0, 32'h0000_0000);
        rd_reg(2'd0, d); check("R3 write-zero no effect", d, 32'hC0F0_0000);
    endtask

    task automatic t_offset();
        logic [N-1:0] d;
        int exp_codes[7] = '{21, 22, 23, 24, 31, 32, 0};
        for (int k = 0; k < 7; k++) begin
            rd_reg(2'd3, d);
            check("R5 offset code sequence", d, N'(exp_codes[k]));
        end
        rd_reg(2'd0, d); check("R6 offset reads drained flags", d, '0);
        check("R8 irq low after drain", N'(irq), 0);
    endtask

    task automatic t_single_clear();
        logic [N-1:0] d;
        wr_reg(2'd1, 32'h0000_0050);
        pulse(32'h0000_0050);
        rd_reg(2'd3, d); check("R5 lowest pending wins", d, 32'd5);
        rd_reg(2'd0, d); check("R6 only reported flag cleared", d, 32'h0000_0040);
        check("R8 irq stays while one pending", N'(irq), 1);
        scrub();
    endtask

    task automatic t_debug();
        logic [N-1:0] d;
        wr_reg(2'd1, '1);
        pulse(32'h0000_0020);
        dbg_mode = 1'b1;
        rd_reg(2'd3, d); check("R7 debug read code", d, 32'd6);
        rd_reg(2'd3, d); check("R7 debug read repeat", d, 32'd6);
        rd_reg(2'd0, d); check("R7 flag kept in debug", d, 32'h0000_0020);
        dbg_mode = 1'b0;
        rd_reg(2'd3, d); check("R6 normal read code", d, 32'd6);
        rd_reg(2'd3, d); check("R6 cleared after normal read", d, 32'd0);
        scrub();
    endtask

    task automatic t_collide();
        logic [N-1:0] d;
        wr_reg(2'd1, 32'h0000_0008);
        pulse(32'h0000_0008);
        wr_reg(2'd0, 32'h0000_0008, 32'h0000_0008);
        rd_reg(2'd0, d); check("R9 set beats write clear", d, 32'h0000_0008);
        rd_reg(2'd3, d, 32'h0000_0008); check("R9 code during collision", d, 32'd4);
        rd_reg(2'd0, d); check("R9 set beats offset clear", d, 32'h0000_0008);
        scrub();
    endtask

    task automatic t_mask();
        logic [N-1:0] d;
        wr_reg(2'd1, 32'h0000_0080);
        pulse(32'h0000_0080);
        wr_reg(2'd2, 32'h0000_0080);
        check("R8 irq masked by enable", N'(irq), 0);
        rd_reg(2'd0, d); check("R3 raw flag kept when masked", d, 32'h0000_0080);
        rd_reg(2'd3, d); check("R5 masked flag not pending", d, 32'd0);
        wr_reg(2'd1, 32'h0000_0080);
        check("R8 irq back on re-enable", N'(irq), 1);
        scrub();
    endtask

    task automatic t_ofs_write();
        logic [N-1:0] d;
        wr_reg(2'd1, 32'h0000_0300);
        pulse(32'h0000_0100);
        wr_reg(2'd3, '1);
        rd_reg(2'd0, d); check("R10 offset write keeps flags", d, 32'h0000_0100);
        rd_reg(2'd1, d); check("R10 offset write keeps enables", d, 32'h0000_0300);
        scrub();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_events();
        t_w1c();
        t_offset();
        scrub();
        t_single_clear();
        t_debug();
        t_collide();
        t_mask();
        t_ofs_write();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule